// File: doc/BRIEF.md
# Cascadable Interrupt Controller

The block gathers up to 32 interrupt request lines into one programmable controller. Each line can be set up on its own to respond to a level or to an edge, and to either polarity. Qualified requests are latched in a status register. Software clears that register by writing ones. An enable register gates the latched requests, and a routing register sends each gated request to one of two outputs: critical or noncritical. The controller also reports which pending, enabled source has the highest priority.

Software reaches the registers over a single-cycle bus made of a 3-bit address, a write strobe, write data and read data. Reads are combinational from the address. Because the noncritical output is a plain registered level, it can drive a request input of a second instance. This lets a parent controller see a whole child controller as one of its own sources.

Source number n always occupies bit 31−n of every register and of the request input vector. Source 0 is therefore the most significant bit and has the highest priority.

Top module: `cic_ctrl`

Register offsets (reg_addr):
- 0: status (reads the latched requests; a write clears the bits where the data holds 1)
- 1: enable
- 2: masked status (read-only)
- 3: trigger mode (0 = level, 1 = edge)
- 4: polarity (1 = active-high / rising, 0 = active-low / falling)
- 5: routing (1 = critical, 0 = noncritical)
- 6: top source number (read-only)
- 7: reads zero

## Requirements
- R1: Out of synchronous reset, the following values hold: status, enable, trigger and routing read 0; polarity reads all ones; both interrupt outputs are low; top_src is 32.
- R2: Source n sits at bit 31−n of src_in and of every register, so source 0 is the MSB.
- R3: Offset 2 reads status AND enable. Writes to offsets 2 and 6 change no register.
- R4: A write to offset 0 clears exactly the status bits where the data is 1. Every other status bit is kept.
- R5: In level mode (trigger bit 0), the status bit is set on every cycle while the input is active. A clear written while the input is still active therefore has no effect. The bit stays latched after the input goes inactive, until it is cleared. An input change reaches status on the third rising clock edge.
- R6: In edge mode (trigger bit 1), status is set once per active edge. A held input does not set the bit again after a clear. An edge that lands in the same cycle as a clear leaves the bit set.
- R7: Polarity bit 1 makes a high level or a rising edge active. Polarity bit 0 makes a low level or a falling edge active.
- R8: crit_irq is the registered OR of the masked status bits whose routing bit is 1. norm_irq is the registered OR of those whose routing bit is 0. Each follows status and enable one clock later.
- R9: top_src is the registered number of the lowest-numbered pending enabled source, or 32 when none is pending. Offset 6 reads the same encoding from the current masked status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Request inputs, source n on bit 31−n |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| crit_irq | output | 1 | Critical interrupt request |
| norm_irq | output | 1 | Noncritical interrupt request, cascadable |
| top_src | output | 6 | Highest-priority pending source, 32 if none |

## Verification
The bench places an edge on the same clock edge as a write-one-to-clear of that bit. A design that lets the clear win would lose that interrupt. It clears a level source while the source is still active; if status simply cleared there, the request would vanish while the source still demands service. Separate tables exercise mixed polarities and routing, and the priority checks put pending bits at both ends of the word. A reversed bit order or a reversed priority scan would report the wrong source number or raise the wrong output. Writes to the read-only offsets are followed by readback, which exposes a register that takes the write.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Register offsets on the 3-bit register bus
  typedef enum logic [2:0] {
    A_STAT = 3'd0,
    A_ENAB = 3'd1,
    A_MASK = 3'd2,
    A_TRIG = 3'd3,
    A_POL  = 3'd4,
    A_CRIT = 3'd5,
    A_TOP  = 3'd6,
    A_RSV  = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/cic_front.sv
// Per-source input conditioning: synchronizer, polarity, edge/level select.
module cic_front #(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] trig,
  input  logic [NSRC-1:0] pol,
  output logic [NSRC-1:0] set_vec
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   act;
    logic                   act_prev;

    always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], src_in[i]};
    end

    // active when the synchronized level matches the polarity bit
    assign act = ~(sync_q[SYNC_STAGES-1] ^ pol[i]);

    always_ff @(posedge clk) begin
      if (rst) act_prev <= 1'b0;
      else     act_prev <= act;
    end

    assign set_vec[i] = trig[i] ? (act & ~act_prev) : act;
  end

endmodule

// File: rtl/cic_prio.sv
// Picks the lowest-numbered source; source n sits at bit NSRC-1-n.
module cic_prio #(
  parameter int NSRC = 32,
  localparam int IDW = $clog2(NSRC) + 1
) (
  input  logic [NSRC-1:0] req,
  output logic [IDW-1:0]  id
);

  always_comb begin
    id = IDW'(NSRC);
    // ascending scan: the highest bit found last wins
    for (int i = 0; i < NSRC; i++) begin
      if (req[i]) id = IDW'(NSRC - 1 - i);
    end
  end

endmodule

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       src_in,
  input  logic [2:0]            reg_addr,
  input  logic                  reg_we,
  input  logic [NSRC-1:0]       reg_wdata,
  output logic [NSRC-1:0]       reg_rdata,
  output logic                  crit_irq,
  output logic                  norm_irq,
  output logic [$clog2(NSRC):0] top_src
);

  localparam int IDW = $clog2(NSRC) + 1;

  logic [NSRC-1:0] stat_q, en_q, trig_q, pol_q, crit_q;
  logic [NSRC-1:0] set_vec, masked, clr_mask;
  logic [IDW-1:0]  enc_id;
  reg_sel_e        sel;

  assign sel = reg_sel_e'(reg_addr);

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      trig_q <= '0;
      pol_q  <= '1;
      crit_q <= '0;
    end else if (reg_we) begin
      case (sel)
        A_ENAB:  en_q   <= reg_wdata;
        A_TRIG:  trig_q <= reg_wdata;
        A_POL:   pol_q  <= reg_wdata;
        A_CRIT:  crit_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  cic_front #(
    .NSRC        (NSRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk     (clk),
    .rst     (rst),
    .src_in  (src_in),
    .trig    (trig_q),
    .pol     (pol_q),
    .set_vec (set_vec)
  );

  // status: write-one-to-clear, a new set in the same cycle wins
  assign clr_mask = (reg_we && sel == A_STAT) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_mask) | set_vec;
  end

  assign masked = stat_q & en_q;

  cic_prio #(.NSRC(NSRC)) u_prio (
    .req (masked),
    .id  (enc_id)
  );

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      crit_irq <= 1'b0;
      norm_irq <= 1'b0;
      top_src  <= IDW'(NSRC);
    end else begin
      crit_irq <= |(masked & crit_q);
      norm_irq <= |(masked & ~crit_q);
      top_src  <= enc_id;
    end
  end

  // read mux
  always_comb begin
    case (sel)
      A_STAT:  reg_rdata = stat_q;
      A_ENAB:  reg_rdata = en_q;
      A_MASK:  reg_rdata = masked;
      A_TRIG:  reg_rdata = trig_q;
      A_POL:   reg_rdata = pol_q;
      A_CRIT:  reg_rdata = crit_q;
      A_TOP:   reg_rdata = NSRC'(enc_id);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cic_chk.sv
module cic_chk
  import cic_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IDW = $clog2(NSRC) + 1
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      reg_addr,
  input logic            reg_we,
  input logic [NSRC-1:0] stat_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] crit_q,
  input logic [NSRC-1:0] set_vec,
  input logic            crit_irq,
  input logic            norm_irq,
  input logic [IDW-1:0]  top_src
);

  logic [NSRC-1:0] prev_m;
  logic [NSRC-1:0] shifted;
  logic            hit;

  always_ff @(posedge clk) prev_m <= stat_q & en_q;

  assign shifted = prev_m >> (IDW'(NSRC - 1) - top_src);
  assign hit = (top_src == IDW'(NSRC)) ? (prev_m == '0)
             : (shifted == {{(NSRC-1){1'b0}}, 1'b1});

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (en_q == '0 && stat_q == '0 && !crit_irq && !norm_irq));

  // R4
  no_silent_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R8
  crit_out_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (crit_irq == |$past(stat_q & en_q & crit_q)));

  // R8
  norm_out_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (norm_irq == |$past(stat_q & en_q & ~crit_q)));

  // R9
  top_pick_chk: assert property (@(posedge clk) disable iff (rst) hit);

endmodule

bind cic_ctrl cic_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_addr (reg_addr),
  .reg_we   (reg_we),
  .stat_q   (stat_q),
  .en_q     (en_q),
  .crit_q   (crit_q),
  .set_vec  (set_vec),
  .crit_irq (crit_irq),
  .norm_irq (norm_irq),
  .top_src  (top_src)
);

// File: tb/cic_ctrl_test.sv
module cic_ctrl_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] O_STAT = 3'd0, O_ENAB = 3'd1, O_MASK = 3'd2,
                         O_TRIG = 3'd3, O_POL = 3'd4, O_CRIT = 3'd5, O_TOP = 3'd6;

  typedef struct packed {
    logic [31:0] pol;
    logic [31:0] crit;
    logic [31:0] en;
    logic [31:0] src;
    logic [31:0] mask;
    logic        ci;
    logic        ni;
    logic [5:0]  id;
  } vec_t;

  // R2 R7 R8 R9: level-mode table
  localparam vec_t TBL [6] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1, 6'd31},
    '{32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h8000_0001, 1'b1, 1'b1, 6'd0},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_0000, 1'b0, 1'b0, 6'd32},
    '{32'h0000_0000, 32'h0000_0000, 32'h00F0_0000, 32'hFF0F_FFFF, 32'h00F0_0000, 1'b0, 1'b1, 6'd8},
    '{32'hFFFF_0000, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FFFF, 1'b1, 1'b0, 6'd16},
    '{32'hFFFF_FFFF, 32'h0010_0000, 32'h0030_0000, 32'h0030_0000, 32'h0030_0000, 1'b1, 1'b1, 6'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        crit_irq, norm_irq;
  logic [5:0]  top_src;

  int total = 0;
  int bad   = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  cic_ctrl uut (
    .clk       (clk),
    .rst       (rst),
    .src_in    (src_in),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .crit_irq  (crit_irq),
    .norm_irq  (norm_irq),
    .top_src   (top_src)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    #1;
    check("R1 crit", 32'(crit_irq), 32'd0);
    check("R1 norm", 32'(norm_irq), 32'd0);
    check("R1 top", 32'(top_src), 32'd32);
    rd(O_ENAB, rv); check("R1 enable", rv, 32'h0);
    rd(O_STAT, rv); check("R1 status", rv, 32'h0);
    rd(O_POL,  rv); check("R1 polarity", rv, 32'hFFFF_FFFF);
    rd(O_TRIG, rv); check("R1 trigger", rv, 32'h0);

    // table walk (R2 R7 R8 R9, level mode)
    for (int k = 0; k < 6; k++) begin
      wr(O_ENAB, 32'h0);
      src_in = ~TBL[k].pol;
      wr(O_POL, TBL[k].pol);
      idle(4);
      wr(O_STAT, 32'hFFFF_FFFF);
      wr(O_CRIT, TBL[k].crit);
      wr(O_ENAB, TBL[k].en);
      src_in = TBL[k].src;
      idle(5);
      @(negedge clk);
      check($sformatf("R8 crit vec%0d", k), 32'(crit_irq), 32'(TBL[k].ci));
      check($sformatf("R8 norm vec%0d", k), 32'(norm_irq), 32'(TBL[k].ni));
      check($sformatf("R9 top vec%0d", k), 32'(top_src), 32'(TBL[k].id));
      rd(O_MASK, rv); check($sformatf("R2 R7 masked vec%0d", k), rv, TBL[k].mask);
    end

    // edge mode setup
    wr(O_ENAB, 32'h0);
    src_in = 32'h0;
    wr(O_POL, 32'hFFFF_FFFF);
    wr(O_CRIT, 32'h0);
    wr(O_TRIG, 32'hFFFF_FFFF);
    idle(4);
    wr(O_STAT, 32'hFFFF_FFFF);
    rd(O_STAT, rv); check("R6 idle after clear", rv, 32'h0);

    // R4 partial write-one-to-clear on latched edges
    src_in = 32'hF000_0000;
    idle(5);
    rd(O_STAT, rv); check("R6 rising edges", rv, 32'hF000_0000);
    wr(O_STAT, 32'h5000_0000);
    rd(O_STAT, rv); check("R4 partial clear", rv, 32'hA000_0000);
    idle(5);
    rd(O_STAT, rv); check("R6 held input no reset", rv, 32'hA000_0000);
    wr(O_ENAB, 32'hFFFF_FFFF);
    idle(2);
    @(negedge clk);
    check("R8 norm edge", 32'(norm_irq), 32'd1);
    check("R9 top edge", 32'(top_src), 32'd0);
    wr(O_STAT, 32'hFFFF_FFFF);
    rd(O_STAT, rv); check("R4 clear all", rv, 32'h0);
    idle(2);
    @(negedge clk);
    check("R8 norm low", 32'(norm_irq), 32'd0);
    check("R9 none", 32'(top_src), 32'd32);

    // R7 falling edge on source 0
    wr(O_POL, 32'h7FFF_FFFF);
    idle(4);
    rd(O_STAT, rv); check("R7 pol change no edge", rv, 32'h0);
    @(negedge clk) src_in = 32'h7000_0000;
    idle(5);
    rd(O_STAT, rv); check("R7 falling edge", rv, 32'h8000_0000);
    wr(O_STAT, 32'hFFFF_FFFF);

    // R6 edge in the same cycle as a clear of that bit
    @(negedge clk) src_in = 32'h7000_0001;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_addr = O_STAT; reg_we = 1'b1; reg_wdata = 32'h0000_0001;
    @(posedge clk); #1;
    reg_we = 1'b0;
    rd(O_STAT, rv); check("R6 edge beats clear", rv, 32'h0000_0001);
    wr(O_STAT, 32'h0000_0001);
    idle(3);
    rd(O_STAT, rv); check("R6 one set per edge", rv, 32'h0);

    // R5 level mode
    src_in = 32'h0;
    wr(O_POL, 32'hFFFF_FFFF);
    wr(O_TRIG, 32'h0);
    idle(4);
    wr(O_STAT, 32'hFFFF_FFFF);
    src_in = 32'h0000_0008;
    idle(5);
    rd(O_STAT, rv); check("R5 level set", rv, 32'h0000_0008);
    wr(O_STAT, 32'h0000_0008);
    rd(O_STAT, rv); check("R5 clear while active", rv, 32'h0000_0008);
    src_in = 32'h0;
    idle(5);
    rd(O_STAT, rv); check("R5 latched after release", rv, 32'h0000_0008);

    // R3 read-only offsets
    wr(O_ENAB, 32'h0000_000C);
    wr(O_MASK, 32'hFFFF_FFFF);
    wr(O_TOP, 32'h0000_0000);
    rd(O_MASK, rv); check("R3 masked", rv, 32'h0000_0008);
    rd(O_ENAB, rv); check("R3 enable untouched", rv, 32'h0000_000C);
    rd(O_TOP, rv);  check("R9 top read", rv, 32'd28);
    wr(O_STAT, 32'h0000_0008);
    rd(O_STAT, rv); check("R5 clear after release", rv, 32'h0);
    rd(O_TOP, rv);  check("R9 top read none", rv, 32'd32);

    finish_run();
  end

endmodule